// File: doc/BRIEF.md
# Software Interrupt Trigger Decoder

This block sits in an interrupt distributor beside the pending-state storage. It watches the distributor's write port for a full-word store to the software-interrupt trigger register. When it sees one, it works out which CPUs the store addresses and which interrupt it names. It then hands both to the pending storage as a single-cycle set-pending pulse vector, one bit per CPU, together with the interrupt ID.

The store data carries a 2-bit target selector and, for the explicit-list mode, a CPU bit list. The CPUs the selector can name are an explicit list, every implemented CPU other than the writer, or the writer alone. The fourth selector code is reserved, and a store that uses it is discarded. Only the four low data bits name the interrupt, so software interrupts are limited to IDs 0 to 15. The number of implemented CPUs is an input, and no CPU at or above that count is ever targeted.

Top module: `sgi_trigger`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pend_set` is all zeros and `pend_id` is zero.
- R2: A store acts only when `wr_en` is high, `wr_addr` equals OFFSET (default 0xF00) and all four bits of `wr_be` are set. A store with any other address or with partial byte enables produces no pulse.
- R3: Selector `wr_data[25:24]` = 0 targets the CPUs whose bits are set in `wr_data[23:16]` (bit 16 is CPU 0), limited to CPUs numbered below `num_cpu`.
- R4: Selector = 1 targets every CPU numbered below `num_cpu` except `wr_cpu`.
- R5: Selector = 2 targets `wr_cpu` alone, provided `wr_cpu` is below `num_cpu`.
- R6: Selector = 3 is reserved: the store is dropped and no pending bit is set.
- R7: The pulse appears on `pend_set` in the cycle after the accepted store. It lasts exactly one cycle, and its set bits are exactly the computed target set, with no other CPU's bit set.
- R8: With each pulse, `pend_id` carries `wr_data[3:0]` of the store that caused it.
- R9: A computed target set that is empty produces no pulse, and `pend_id` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Distributor write strobe |
| wr_addr | input | ADDR_W (12) | Distributor byte offset of the store |
| wr_be | input | 4 | Byte enables of the store |
| wr_data | input | 32 | Store data |
| wr_cpu | input | CPU_W (3) | Number of the CPU issuing the store |
| num_cpu | input | CNT_W (4) | Count of implemented CPUs |
| pend_set | output | NCPU (8) | Per-CPU set-pending pulse |
| pend_id | output | 4 | Interrupt ID for the pulse |

## Verification
The checker assumes that `num_cpu` and `wr_cpu` are stable during the cycle in which a store is sampled. It also assumes that `num_cpu` never exceeds NCPU. The bench drives every store on the falling edge, holds it for exactly one rising edge, and changes the CPU count only between stores. It keeps `num_cpu` within 1 to NCPU. It covers `wr_cpu` values both inside and outside the implemented range, so the R5 exclusion is exercised at the ports.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  // Target selector carried in the store data
  typedef enum logic [1:0] {
    TGT_LIST   = 2'd0,
    TGT_OTHERS = 2'd1,
    TGT_SELF   = 2'd2,
    TGT_RSVD   = 2'd3
  } tgt_sel_e;

  localparam int SEL_LSB  = 24;
  localparam int LIST_LSB = 16;
  localparam int LIST_W   = 8;
  localparam int ID_W     = 4;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode #(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] OFFSET = 12'hF00
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(OFFSET);

  always_comb hit = wr_en && (wr_addr == MATCH) && (&wr_be);
endmodule

// File: rtl/sgi_target.sv
module sgi_target
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3,
  parameter int CNT_W = 4
) (
  input  tgt_sel_e         sel,
  input  logic [NCPU-1:0]  list,
  input  logic [CPU_W-1:0] req_cpu,
  input  logic [CNT_W-1:0] num_cpu,
  output logic [NCPU-1:0]  mask
);
  logic [NCPU-1:0] impl;
  logic [NCPU-1:0] self_bit;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assign impl[i]     = (num_cpu > CNT_W'(i));
    assign self_bit[i] = (req_cpu == CPU_W'(i));
  end

  always_comb begin
    unique case (sel)
      TGT_LIST:   mask = list & impl;
      TGT_OTHERS: mask = impl & ~self_bit;
      TGT_SELF:   mask = impl & self_bit;
      default:    mask = '0;
    endcase
  end
endmodule

// File: rtl/sgi_trigger.sv
module sgi_trigger
  import sgi_pkg::*;
#(
  parameter int          NCPU   = 8,
  parameter int          ADDR_W = 12,
  parameter logic [11:0] OFFSET = 12'hF00,
  localparam int         CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int         CNT_W  = $clog2(NCPU + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic [CPU_W-1:0]  wr_cpu,
  input  logic [CNT_W-1:0]  num_cpu,
  output logic [NCPU-1:0]   pend_set,
  output logic [ID_W-1:0]   pend_id
);
  if (NCPU > LIST_W || NCPU < 1) begin : g_bad_ncpu
    initial $error("sgi_trigger: NCPU must lie in 1..%0d", LIST_W);
  end

  logic            hit;
  logic [NCPU-1:0] tgt_mask;
  tgt_sel_e        sel;

  assign sel = tgt_sel_e'(wr_data[SEL_LSB +: 2]);

  sgi_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_be  (wr_be),
    .hit    (hit)
  );

  sgi_target #(.NCPU(NCPU), .CPU_W(CPU_W), .CNT_W(CNT_W)) u_tgt (
    .sel    (sel),
    .list   (wr_data[LIST_LSB +: NCPU]),
    .req_cpu(wr_cpu),
    .num_cpu(num_cpu),
    .mask   (tgt_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_set <= '0;
      pend_id  <= '0;
    end else if (hit && (|tgt_mask)) begin
      pend_set <= tgt_mask;
      pend_id  <= wr_data[ID_W-1:0];
    end else begin
      pend_set <= '0;
    end
  end
endmodule

// File: rtl/sgi_trigger_chk.sv
module sgi_trigger_chk
  import sgi_pkg::*;
#(
  parameter int          NCPU   = 8,
  parameter int          ADDR_W = 12,
  parameter logic [11:0] OFFSET = 12'hF00,
  parameter int          CPU_W  = 3,
  parameter int          CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_be,
  input logic [31:0]       wr_data,
  input logic [CPU_W-1:0]  wr_cpu,
  input logic [CNT_W-1:0]  num_cpu,
  input logic [NCPU-1:0]   pend_set,
  input logic [ID_W-1:0]   pend_id
);
  logic taken;
  assign taken = wr_en && (wr_addr == ADDR_W'(OFFSET)) && (wr_be == 4'hF);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pend_set == '0 && pend_id == '0)); // R1
  AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (rst) !taken |=> pend_set == '0); // R2
  AST_IMPL_ONLY: assert property (@(posedge clk) disable iff (rst) taken |=> (({{(32-NCPU){1'b0}}, pend_set} >> $past(num_cpu)) == 32'd0)); // R3
  AST_NOT_WRITER: assert property (@(posedge clk) disable iff (rst) (taken && wr_data[25:24] == 2'd1) |=> !pend_set[$past(wr_cpu)]); // R4
  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (rst) (taken && wr_data[25:24] == 2'd2) |=> $onehot0(pend_set)); // R5
  AST_RSVD_DROP: assert property (@(posedge clk) disable iff (rst) (taken && wr_data[25:24] == 2'd3) |=> pend_set == '0); // R6
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (rst) taken |=> (pend_set == '0 || pend_id == $past(wr_data[3:0]))); // R8
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst) (pend_set == '0 && !taken) |=> $stable(pend_id)); // R9
endmodule

bind sgi_trigger sgi_trigger_chk #(
  .NCPU(NCPU), .ADDR_W(ADDR_W), .OFFSET(OFFSET), .CPU_W(CPU_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_sgi_trigger.sv
`timescale 1ns/1ps
module sim_sgi_trigger;
  localparam int NCPU = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_cpu = '0;
  logic [3:0]  num_cpu = 4'd8;
  logic [7:0]  pend_set;
  logic [3:0]  pend_id;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] last_id = '0;

  always #2 clk = ~clk;

  sgi_trigger u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_mask(input logic [31:0] d, input logic [2:0] cpu, input logic [3:0] n);
    logic [7:0] m = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (i < n) begin
        case (d[25:24])
          2'd0: m[i] = d[16+i];
          2'd1: m[i] = (i != cpu);
          2'd2: m[i] = (i == cpu);
          default: m[i] = 1'b0;
        endcase
      end
    end
    return m;
  endfunction

  // One store, result checked on the following falling edge, then pulse end checked
  task automatic store(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d,
                       input logic [2:0] cpu, input logic [7:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; wr_cpu = cpu;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(pend_set == exp, req, {24'd0, pend_set}, {24'd0, exp});
    if (exp != '0) last_id = d[3:0];
    check(pend_id == last_id, {req, " R8 R9 id"}, {28'd0, pend_id}, {28'd0, last_id});
    @(negedge clk);
    check(pend_set == '0, {req, " R7 width"}, {24'd0, pend_set}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pend_set == '0 && pend_id == '0, "R1", {20'd0, pend_id, pend_set}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(pend_set == '0, "R1 after", {24'd0, pend_set}, 32'd0);
  endtask

  task automatic t_list;
    logic [31:0] d;
    num_cpu = 4'd8;
    d = 32'h00A5_0003;
    store(12'hF00, 4'hF, d, 3'd1, expect_mask(d, 3'd1, 4'd8), "R3 list");
    num_cpu = 4'd4;
    d = 32'h00FF_0007;
    store(12'hF00, 4'hF, d, 3'd0, expect_mask(d, 3'd0, 4'd4), "R3 list masked");
  endtask

  task automatic t_others;
    logic [31:0] d = 32'h0100_000B;
    num_cpu = 4'd8;
    store(12'hF00, 4'hF, d, 3'd5, expect_mask(d, 3'd5, 4'd8), "R4 others");
    num_cpu = 4'd3;
    store(12'hF00, 4'hF, d, 3'd0, expect_mask(d, 3'd0, 4'd3), "R4 others small");
  endtask

  task automatic t_self;
    logic [31:0] d = 32'h0200_000E;
    num_cpu = 4'd8;
    store(12'hF00, 4'hF, d, 3'd6, 8'h40, "R5 self");
    num_cpu = 4'd2;
    store(12'hF00, 4'hF, 32'h0200_0001, 3'd4, 8'h00, "R5 self outside");
  endtask

  task automatic t_rsvd;
    num_cpu = 4'd8;
    store(12'hF00, 4'hF, 32'h03FF_0009, 3'd2, 8'h00, "R6 reserved");
  endtask

  task automatic t_gate;
    num_cpu = 4'd8;
    store(12'hF00, 4'h3, 32'h00FF_0004, 3'd0, 8'h00, "R2 half");
    store(12'hF00, 4'h1, 32'h00FF_0004, 3'd0, 8'h00, "R2 byte");
    store(12'hF04, 4'hF, 32'h00FF_0004, 3'd0, 8'h00, "R2 addr");
    store(12'hF00, 4'hF, 32'h00FF_0004, 3'd0, 8'hFF, "R2 full");
  endtask

  task automatic t_empty;
    num_cpu = 4'd4;
    store(12'hF00, 4'hF, 32'h00F0_000C, 3'd0, 8'h00, "R9 empty list");
    num_cpu = 4'd1;
    store(12'hF00, 4'hF, 32'h0100_0002, 3'd0, 8'h00, "R9 empty others");
  endtask

  task automatic t_back_to_back;
    num_cpu = 4'd8;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'hF00; wr_be = 4'hF; wr_data = 32'h0001_0005; wr_cpu = 3'd0;
    @(negedge clk);
    check(pend_set == 8'h01 && pend_id == 4'd5, "R7 b2b first", {20'd0, pend_id, pend_set}, 32'h501);
    wr_data = 32'h0080_000A;
    @(negedge clk);
    wr_en = 1'b0;
    check(pend_set == 8'h80 && pend_id == 4'hA, "R7 b2b second", {20'd0, pend_id, pend_set}, 32'hA80);
    last_id = 4'hA;
    @(negedge clk);
    check(pend_set == '0, "R7 b2b end", {24'd0, pend_set}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_list();
    t_others();
    t_self();
    t_rsvd();
    t_gate();
    t_empty();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule